// File: doc/BRIEF.md
# Signed/Unsigned Array Multiplier

A purely combinational multiplier that forms the full double-width product of two equal-width operands. The product comes from an explicit array: one row of AND gates per multiplier bit gives a partial product, each row is shifted by its bit position, and the rows are summed one after another through ripple rows of half and full adder cells. A single mode input selects between unsigned and two's-complement operands, and the block holds no state. An output change follows an input change after logic delay only.

The signed behaviour comes in two variants, picked by an elaboration parameter. The magnitude variant takes the absolute value of each negative operand and runs the unsigned array. It then negates the result when exactly one operand was negative. The extension variant feeds the operands straight into the array and widens every partial-product row with the multiplicand's sign before it is added. That variant gives a correct signed result only while the multiplier operand is non-negative.

Top module: `amul_array`

## Requirements
- R1: Row i of the array is the multiplicand ANDed with multiplier bit i, weighted by 2^i. A zero multiplier gives a zero product in either mode. A multiplier of 2^i in unsigned mode gives the multiplicand shifted left by i.
- R2: With `signed_mode` = 0 the product is the exact unsigned 2·WIDTH-bit product, never truncated. At WIDTH=4, 1011 × 1110 gives 10011010.
- R3: With `signed_mode` = 1 both operands are read as two's complement and the product is the two's-complement 2·WIDTH-bit result. At WIDTH=4, 1011 × 0011 gives 11110001 (−15) in signed mode and 00100001 in unsigned mode.
- R4: With SIGN_METHOD = SGN_MAGNITUDE, every signed operand pair gives the correct product, including the most negative value on either or both inputs. At WIDTH=8, 0x80 × 0x80 gives 0x4000 and 0x80 × 0x7F gives 0xC080.
- R5: With SIGN_METHOD = SGN_EXTEND, signed mode gives the correct product for any multiplicand whenever the multiplier's top bit is 0.
- R6: The SIGN_METHOD parameter selects which signed variant is built. Both variants give identical, exact results in unsigned mode for every operand pair.
- R7: The block is combinational. A new input value shows at `product` after settling, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| multiplicand | input | WIDTH | Operand whose copies form the partial-product rows |
| multiplier | input | WIDTH | Operand whose bits gate the rows |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| product | output | 2*WIDTH | Full-width product |

## Verification
The hardest case to reach is the most negative operand in the magnitude variant. There, negating 100…0 gives back the same bit pattern, which the unsigned array must read as +2^(WIDTH−1). The bench drives 0x80 against 0x80, 0x7F and 1 directly, and it also sweeps every multiplicand against a spread of multipliers that includes the top bit. The extension variant is driven only with multipliers whose top bit is clear when it is in signed mode, so that its stated operating range is covered in full. Unsigned sweeps are compared across both variants.

// File: rtl/amul_pkg.sv
// Shared definitions for the array multiplier.
// Assumes nothing beyond a standard elaboration flow.
package amul_pkg;

    // Which circuit provides two's-complement multiplication.
    typedef enum logic {
        SGN_MAGNITUDE = 1'b0,  // absolute values in, conditional negate out
        SGN_EXTEND    = 1'b1   // sign-extended rows summed directly
    } sign_method_e;

endpackage

// File: rtl/amul_ha.sv
// Half adder cell: sum and carry of two bits.
// Assumes single-bit inputs; no timing state.
module amul_ha (
    input  logic x,
    input  logic y,
    output logic s,
    output logic c
);

    // Sum and carry of the two inputs.
    assign s = x ^ y;
    assign c = x & y;

endmodule

// File: rtl/amul_fa.sv
// Full adder cell: sum and carry of three bits.
// Assumes single-bit inputs; no timing state.
module amul_fa (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);

    // Sum and majority carry.
    assign s  = x ^ y ^ ci;
    assign co = (x & y) | (x & ci) | (y & ci);

endmodule

// File: rtl/amul_cneg.sv
// Conditional two's-complement negation: q = en ? -d : d (modulo 2^W).
// Built from an inverter row and a half-adder increment chain.
// Assumes W >= 1; the carry out of the top bit is discarded.
module amul_cneg #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    input  logic         en,
    output logic [W-1:0] q
);

    logic [W-1:0] inv;
    logic [W-1:0] cy;

    // Invert every bit when negating; seed the increment with en.
    assign inv   = d ^ {W{en}};
    assign cy[0] = en;

    for (genvar i = 0; i < W - 1; i++) begin : g_inc
        amul_ha u_ha (.x(inv[i]), .y(cy[i]), .s(q[i]), .c(cy[i+1]));
    end

    // Top bit needs no carry out.
    assign q[W-1] = inv[W-1] ^ cy[W-1];

endmodule

// File: rtl/amul_ppgen.sv
// Partial-product generator: one AND row per multiplier bit, optionally
// widened with the row's sign bit, then shifted to its bit weight.
// Assumes PW >= WIDTH; sext is applied to every row alike.
module amul_ppgen #(
    parameter int WIDTH = 8,
    parameter int PW    = 2 * WIDTH
) (
    input  logic [WIDTH-1:0]         op_a,
    input  logic [WIDTH-1:0]         op_b,
    input  logic                     sext,
    output logic [WIDTH-1:0][PW-1:0] rows
);

    localparam int EXT = PW - WIDTH;

    for (genvar i = 0; i < WIDTH; i++) begin : g_row
        logic [WIDTH-1:0] and_row;
        logic [PW-1:0]    wide_row;

        // Gate the multiplicand with multiplier bit i.
        assign and_row  = op_a & {WIDTH{op_b[i]}};
        // Widen with zeros, or with the row sign when extending.
        assign wide_row = {{EXT{sext & and_row[WIDTH-1]}}, and_row};
        // Place the row at weight 2^i.
        assign rows[i]  = wide_row << i;
    end

endmodule

// File: rtl/amul_rowadd.sv
// One accumulation row of the array: ripple sum of two PW-bit words.
// The least significant cell is a half adder, the others are full adders;
// the carry out of the top cell is dropped (result modulo 2^PW).
// Assumes PW >= 2.
module amul_rowadd #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] x,
    input  logic [PW-1:0] y,
    output logic [PW-1:0] s
);

    logic [PW-1:0] cy;

    // Edge cell: no incoming carry.
    amul_ha u_edge (.x(x[0]), .y(y[0]), .s(s[0]), .c(cy[1]));

    // Inner cells.
    for (genvar i = 1; i < PW - 1; i++) begin : g_cell
        amul_fa u_fa (.x(x[i]), .y(y[i]), .ci(cy[i]), .s(s[i]), .co(cy[i+1]));
    end

    // Top cell: sum only.
    assign s[PW-1] = x[PW-1] ^ y[PW-1] ^ cy[PW-1];

    assign cy[0] = 1'b0;

endmodule

// File: rtl/amul_array.sv
// Combinational WIDTH x WIDTH array multiplier with a 2*WIDTH product.
// signed_mode selects two's-complement operands; SIGN_METHOD picks the
// signed circuit. SGN_EXTEND is only exact in signed mode when the
// multiplier's top bit is 0. Assumes WIDTH >= 2. Holds no state.
module amul_array
    import amul_pkg::*;
#(
    parameter int           WIDTH       = 8,
    parameter sign_method_e SIGN_METHOD = SGN_MAGNITUDE
) (
    input  logic [WIDTH-1:0]   multiplicand,
    input  logic [WIDTH-1:0]   multiplier,
    input  logic               signed_mode,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW = 2 * WIDTH;

    logic [WIDTH-1:0]         op_a;
    logic [WIDTH-1:0]         op_b;
    logic                     sext;
    logic [WIDTH-1:0][PW-1:0] rows;
    logic [PW-1:0]            acc [WIDTH];
    logic [PW-1:0]            raw;

    if (SIGN_METHOD == SGN_MAGNITUDE) begin : g_mag
        logic neg_a;
        logic neg_b;

        // Operand signs matter only in signed mode.
        assign neg_a = signed_mode & multiplicand[WIDTH-1];
        assign neg_b = signed_mode & multiplier[WIDTH-1];

        // Magnitudes feed an unsigned array.
        amul_cneg #(.W(WIDTH)) u_abs_a (.d(multiplicand), .en(neg_a), .q(op_a));
        amul_cneg #(.W(WIDTH)) u_abs_b (.d(multiplier),   .en(neg_b), .q(op_b));
        assign sext = 1'b0;

        // Restore the sign when the operand signs differ.
        amul_cneg #(.W(PW)) u_fix (.d(raw), .en(neg_a ^ neg_b), .q(product));
    end else begin : g_ext
        // Operands go straight in; rows carry the multiplicand sign.
        assign op_a    = multiplicand;
        assign op_b    = multiplier;
        assign sext    = signed_mode;
        assign product = raw;
    end

    amul_ppgen #(.WIDTH(WIDTH), .PW(PW)) u_pp (
        .op_a (op_a),
        .op_b (op_b),
        .sext (sext),
        .rows (rows)
    );

    // First row seeds the accumulation chain.
    assign acc[0] = rows[0];

    for (genvar i = 1; i < WIDTH; i++) begin : g_acc
        amul_rowadd #(.PW(PW)) u_row (.x(acc[i-1]), .y(rows[i]), .s(acc[i]));
    end

    assign raw = acc[WIDTH-1];

endmodule

// File: rtl/amul_array_chk.sv
// Checker for amul_array: compares the product with an arithmetic
// reference whenever inputs or output move. Assumes a settled output.
module amul_array_chk
    import amul_pkg::*;
#(
    parameter int           WIDTH       = 8,
    parameter sign_method_e SIGN_METHOD = SGN_MAGNITUDE
) (
    input logic [WIDTH-1:0]   multiplicand,
    input logic [WIDTH-1:0]   multiplier,
    input logic               signed_mode,
    input logic [2*WIDTH-1:0] product
);

    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] ref_u;
    logic [PW-1:0] ref_s;

    // Reference products and assertions on every input change.
    always_comb begin
        ref_u = PW'(multiplicand) * PW'(multiplier);
        ref_s = PW'($signed(multiplicand)) * PW'($signed(multiplier));

        if (multiplier == '0) begin
            a_r1_zero_multiplier: assert (product == '0)
                else $error("R1 zero multiplier gave %h", product);
        end
        if (!signed_mode) begin
            a_r2_unsigned_exact: assert (product == ref_u)
                else $error("R2 unsigned %h expected %h", product, ref_u);
        end
        if (signed_mode && SIGN_METHOD == SGN_MAGNITUDE) begin
            a_r4_magnitude_signed: assert (product == ref_s)
                else $error("R4 signed %h expected %h", product, ref_s);
        end
        if (signed_mode && SIGN_METHOD == SGN_EXTEND && !multiplier[WIDTH-1]) begin
            a_r5_extend_signed: assert (product == ref_s)
                else $error("R5 signed %h expected %h", product, ref_s);
        end
        if (signed_mode && ref_s != '0
            && (SIGN_METHOD == SGN_MAGNITUDE || !multiplier[WIDTH-1])) begin
            a_r3_product_sign: assert (product[PW-1] == (multiplicand[WIDTH-1] ^ multiplier[WIDTH-1]))
                else $error("R3 product sign wrong: %h", product);
        end
    end

endmodule

bind amul_array amul_array_chk #(.WIDTH(WIDTH), .SIGN_METHOD(SIGN_METHOD)) u_chk (
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .signed_mode  (signed_mode),
    .product      (product)
);

// File: tb/sim_amul_array.sv
// Directed bench for amul_array: four instances (two widths, two signed
// variants) share stimulus; each scenario task checks its own results.
module sim_amul_array;
    import amul_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic        mode = 1'b0;
    logic [15:0] p_mag8, p_ext8;
    logic [7:0]  p_mag4, p_ext4;
    int          n_vec = 0;
    int          n_bad = 0;

    // 125 MHz clock paces the stimulus.
    always #4 clk = ~clk;

    amul_array #(.WIDTH(8), .SIGN_METHOD(SGN_MAGNITUDE)) u0 (
        .multiplicand(a8), .multiplier(b8), .signed_mode(mode), .product(p_mag8));
    amul_array #(.WIDTH(8), .SIGN_METHOD(SGN_EXTEND)) u1 (
        .multiplicand(a8), .multiplier(b8), .signed_mode(mode), .product(p_ext8));
    amul_array #(.WIDTH(4), .SIGN_METHOD(SGN_MAGNITUDE)) u2 (
        .multiplicand(a4), .multiplier(b4), .signed_mode(mode), .product(p_mag4));
    amul_array #(.WIDTH(4), .SIGN_METHOD(SGN_EXTEND)) u3 (
        .multiplicand(a4), .multiplier(b4), .signed_mode(mode), .product(p_ext4));

    function automatic logic [15:0] ref8(logic [7:0] a, logic [7:0] b, logic m);
        logic signed [15:0] sa, sb;
        logic [15:0] ua, ub;
        sa = $signed(a); sb = $signed(b);
        ua = {8'h00, a}; ub = {8'h00, b};
        return m ? 16'(sa * sb) : 16'(ua * ub);
    endfunction

    function automatic logic [7:0] ref4(logic [3:0] a, logic [3:0] b, logic m);
        logic signed [7:0] sa, sb;
        logic [7:0] ua, ub;
        sa = $signed(a); sb = $signed(b);
        ua = {4'h0, a}; ub = {4'h0, b};
        return m ? 8'(sa * sb) : 8'(ua * ub);
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one vector after a rising edge; results are read at the falling edge.
    task automatic drive(logic [7:0] a, logic [7:0] b, logic [3:0] c, logic [3:0] d, logic m);
        @(posedge clk);
        a8 = a; b8 = b; a4 = c; b4 = d; mode = m;
        @(negedge clk);
    endtask

    task automatic t_reset;
        drive(8'h00, 8'h00, 4'h0, 4'h0, 1'b0);
        check("R1 idle u0", p_mag8, 16'h0000);
        check("R1 idle u1", p_ext8, 16'h0000);
        check("R1 idle u2", {8'h00, p_mag4}, 16'h0000);
        check("R1 idle u3", {8'h00, p_ext4}, 16'h0000);
    endtask

    task automatic t_r2_example;
        drive(8'd11, 8'd14, 4'b1011, 4'b1110, 1'b0);
        check("R2 1011x1110 u2", {8'h00, p_mag4}, 16'h009A);
        check("R2 1011x1110 u3", {8'h00, p_ext4}, 16'h009A);
        check("R2 11x14 u0", p_mag8, 16'd154);
        check("R2 11x14 u1", p_ext8, 16'd154);
    endtask

    task automatic t_r3_example;
        drive(8'hFB, 8'h03, 4'b1011, 4'b0011, 1'b1);
        check("R3 -5x3 u2", {8'h00, p_mag4}, 16'h00F1);
        check("R3 -5x3 u3", {8'h00, p_ext4}, 16'h00F1);
        check("R3 -5x3 u0", p_mag8, 16'hFFF1);
        check("R3 -5x3 u1", p_ext8, 16'hFFF1);
        drive(8'hFB, 8'h03, 4'b1011, 4'b0011, 1'b0);
        check("R3 unsigned 11x3 u2", {8'h00, p_mag4}, 16'h0021);
        check("R3 unsigned 251x3 u0", p_mag8, 16'h02F1);
    endtask

    task automatic t_r1_rows;
        for (int i = 0; i < 8; i++) begin
            drive(8'hA5, 8'(1 << i), 4'b1101, 4'(1 << (i % 4)), 1'b0);
            check("R1 single row u0", p_mag8, 16'h00A5 << i);
            check("R1 single row u1", p_ext8, 16'h00A5 << i);
            check("R1 single row u2", {8'h00, p_mag4}, 16'h000D << (i % 4));
        end
        drive(8'hFF, 8'h00, 4'hF, 4'h0, 1'b1);
        check("R1 zero multiplier u0", p_mag8, 16'h0000);
        check("R1 zero multiplier u1", p_ext8, 16'h0000);
        check("R1 zero multiplier u3", {8'h00, p_ext4}, 16'h0000);
    endtask

    task automatic t_r4_most_negative;
        drive(8'h80, 8'h80, 4'h8, 4'h8, 1'b1);
        check("R4 min x min u0", p_mag8, 16'h4000);
        check("R4 min x min u2", {8'h00, p_mag4}, 16'h0040);
        drive(8'h80, 8'h7F, 4'h8, 4'h7, 1'b1);
        check("R4 min x max u0", p_mag8, 16'hC080);
        check("R4 min x max u2", {8'h00, p_mag4}, 16'h00C8);
        check("R5 min x max u1", p_ext8, 16'hC080);
        check("R5 min x max u3", {8'h00, p_ext4}, 16'h00C8);
        drive(8'h7F, 8'h80, 4'h7, 4'h8, 1'b1);
        check("R4 max x min u0", p_mag8, 16'hC080);
        drive(8'h80, 8'h01, 4'h8, 4'h1, 1'b1);
        check("R4 min x 1 u0", p_mag8, 16'hFF80);
    endtask

    task automatic t_r5_extend_sweep;
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                drive(8'(ia), 8'(ib * 8), 4'(ia), 4'(ib % 8), 1'b1);
                check("R5 extend u1", p_ext8, ref8(8'(ia), 8'(ib * 8), 1'b1));
                check("R5 extend u3", {8'h00, p_ext4}, {8'h00, ref4(4'(ia), 4'(ib % 8), 1'b1)});
            end
        end
    endtask

    task automatic t_r6_unsigned_sweep;
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                drive(8'(ia), 8'(ib * 17), 4'(ia), 4'(ib), 1'b0);
                check("R6 unsigned u0", p_mag8, ref8(8'(ia), 8'(ib * 17), 1'b0));
                check("R6 unsigned u1", p_ext8, ref8(8'(ia), 8'(ib * 17), 1'b0));
                check("R6 unsigned u2", {8'h00, p_mag4}, {8'h00, ref4(4'(ia), 4'(ib), 1'b0)});
                check("R6 unsigned u3", {8'h00, p_ext4}, {8'h00, ref4(4'(ia), 4'(ib), 1'b0)});
            end
        end
    endtask

    task automatic t_r4_signed_sweep;
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 16; ib++) begin
                drive(8'(ia), 8'(ib * 17), 4'(ia), 4'(ib), 1'b1);
                check("R4 signed u0", p_mag8, ref8(8'(ia), 8'(ib * 17), 1'b1));
                check("R4 signed u2", {8'h00, p_mag4}, {8'h00, ref4(4'(ia), 4'(ib), 1'b1)});
            end
        end
    endtask

    task automatic t_r7_combinational;
        @(negedge clk);
        a8 = 8'd3; b8 = 8'd5; mode = 1'b0;
        #1;
        check("R7 settles without edge", p_mag8, 16'd15);
        a8 = 8'd6;
        #1;
        check("R7 follows new input", p_mag8, 16'd30);
        mode = 1'b1; b8 = 8'hFF;
        #1;
        check("R7 follows mode", p_mag8, 16'hFFFA);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset;
        t_r2_example;
        t_r3_example;
        t_r1_rows;
        t_r4_most_negative;
        t_r5_extend_sweep;
        t_r6_unsigned_sweep;
        t_r4_signed_sweep;
        t_r7_combinational;
        summary;
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #1600000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary;
        $finish;
    end

endmodule